// File: doc/BRIEF.md
# Boot Image Copy Engine

This block holds a short boot program in a 256-dword retention memory that keeps its contents while the rest of the processor sleeps. A register port lets software fill that memory, choose where a copy starts in it, where the copy lands in the processor's instruction memory, and how many dwords to move. Setting the start bit launches the copy. The engine then emits one write per dword on a plain memory write port.

While the copy runs, the start bit reads back as 1. It drops to 0 when the copy finishes, so software can poll it. A done flag in a status register records completion. Software can also set an arm bit. While armed, every power-up event pulse replays the copy already programmed, with no further software action. This lets the processor's instruction memory be refilled each time it wakes.

The port addresses dwords. When the top address bit is set, the access goes to the retention memory. Otherwise it goes to the register file.

Top module: `boot_copy_engine`

## Requirements
- R1: After reset the control register (offset 0) and the status register (offset 4) read 0, and no instruction-memory write is issued.
- R2: A copy writes `count` dwords. Write i goes to address `dst + i` (modulo the instruction-memory size) and carries retention word `src + i`. The writes are issued in ascending order.
- R3: Control bit 31 is the start bit. Writing 1 to it starts a copy. It reads 1 from the cycle after the start until the copy completes, then reads 0.
- R4: Status bit 0 is the done flag. It becomes 1 when a copy completes and returns to 0 when the next copy starts. It is never 1 while a copy runs.
- R5: A count of 0 completes at once with done set and issues no instruction-memory write.
- R6: Source word addresses wrap modulo 256, so a copy that runs past the last word continues at word 0. No address outside the memory is read.
- R7: A start request made while a copy runs is ignored. The running copy keeps its source, destination and count, even when those registers are rewritten mid-copy.
- R8: Control bit 30 is the arm bit and reads back as written. While it is 1, a one-cycle pulse on `pwr_up_evt` starts the same copy that a software start would start.
- R9: A `pwr_up_evt` pulse while the arm bit is 0 starts nothing. No write is issued, and both the start bit and the done flag keep their values.
- R10: With `bus_addr[8]` = 1, `bus_addr[7:0]` selects a retention word that software can write and read back. Copies never change its contents.
- R11: The source register (offset 1), the destination register (offset 2) and the count register (offset 3) read back the values written to them, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register/memory port |
| bus_addr | input | 9 | Dword address; bit 8 selects the retention memory |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwr_up_evt | input | 1 | Power-up event pulse |
| imem_we | output | 1 | Instruction-memory write strobe |
| imem_addr | output | 14 | Instruction-memory dword address |
| imem_wdata | output | 32 | Instruction-memory write data |

## Verification
Short directed copies from word 0 show that the order of the writes and the address pairing are correct. A copy starting near word 255 separates correct modulo wrap from an overrun. A full 256-dword copy and random copies of up to 300 dwords check long runs and repeated wrap, and they run against retention contents that are rewritten between copies, so stale data is caught. A zero-count copy, a second start plus a source rewrite mid-copy, and event pulses while armed and disarmed show whether start requests are honoured or ignored in exactly the conditions the requirements give.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;
   localparam int WORD_W        = 32;
   localparam int CTRL_GO_BIT   = 31;
   localparam int CTRL_ARM_BIT  = 30;
   localparam int STAT_DONE_BIT = 0;

   typedef enum logic [2:0] {
      SEL_CTRL = 3'd0,
      SEL_SRC  = 3'd1,
      SEL_DST  = 3'd2,
      SEL_CNT  = 3'd3,
      SEL_STAT = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/bcopy_sram.sv
module bcopy_sram #(
   parameter int WORDS = 256,
   parameter int AW    = $clog2(WORDS),
   parameter int DW    = 32
) (
   input  logic          clk,
   input  logic          sw_we,
   input  logic [AW-1:0] sw_addr,
   input  logic [DW-1:0] sw_wdata,
   output logic [DW-1:0] sw_rdata,
   input  logic          eng_re,
   input  logic [AW-1:0] eng_addr,
   output logic [DW-1:0] eng_rdata
);
   // retention array: no reset, contents survive everything but writes
   logic [DW-1:0] mem_q [WORDS];

   always_ff @(posedge clk) begin
      if (sw_we)  mem_q[sw_addr] <= sw_wdata;
      if (eng_re) eng_rdata      <= mem_q[eng_addr];
   end

   assign sw_rdata = mem_q[sw_addr];
endmodule

// File: rtl/bcopy_regs.sv
module bcopy_regs
   import boot_copy_pkg::*;
#(
   parameter int SRAM_AW = 8,
   parameter int IMEM_AW = 14,
   parameter int CNT_W   = SRAM_AW + 1,
   localparam int ADDR_W = SRAM_AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [WORD_W-1:0]  bus_wdata,
   output logic [WORD_W-1:0]  bus_rdata,
   input  logic               pwr_up_evt,
   input  logic               busy,
   input  logic               done,
   input  logic [WORD_W-1:0]  sram_rdata,
   output logic               sram_we,
   output logic [SRAM_AW-1:0] src_q,
   output logic [IMEM_AW-1:0] dst_q,
   output logic [CNT_W-1:0]   cnt_q,
   output logic               arm_q,
   output logic               sw_start_req,
   output logic               start_pulse
);
   logic     in_mem;
   logic     reg_we;
   reg_sel_e sel;

   assign in_mem  = bus_addr[ADDR_W-1];
   assign sel     = reg_sel_e'(bus_addr[2:0]);
   assign reg_we  = bus_we && !in_mem;
   assign sram_we = bus_we && in_mem;

   assign sw_start_req = reg_we && (sel == SEL_CTRL) && bus_wdata[CTRL_GO_BIT];
   // one launch per idle period; requests during a copy are dropped
   assign start_pulse  = (sw_start_req || (pwr_up_evt && arm_q)) && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         cnt_q <= '0;
         arm_q <= 1'b0;
      end else if (reg_we) begin
         case (sel)
            SEL_CTRL: arm_q <= bus_wdata[CTRL_ARM_BIT];
            SEL_SRC:  src_q <= bus_wdata[SRAM_AW-1:0];
            SEL_DST:  dst_q <= bus_wdata[IMEM_AW-1:0];
            SEL_CNT:  cnt_q <= bus_wdata[CNT_W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (in_mem) begin
         bus_rdata = sram_rdata;
      end else begin
         case (sel)
            SEL_CTRL: begin
               bus_rdata[CTRL_GO_BIT]  = busy;
               bus_rdata[CTRL_ARM_BIT] = arm_q;
            end
            SEL_SRC:  bus_rdata[SRAM_AW-1:0] = src_q;
            SEL_DST:  bus_rdata[IMEM_AW-1:0] = dst_q;
            SEL_CNT:  bus_rdata[CNT_W-1:0]   = cnt_q;
            SEL_STAT: bus_rdata[STAT_DONE_BIT] = done;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/bcopy_seq.sv
module bcopy_seq
   import boot_copy_pkg::*;
#(
   parameter int SRAM_AW   = 8,
   parameter int IMEM_AW   = 14,
   parameter int CNT_W     = SRAM_AW + 1,
   parameter bit BACK2BACK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [SRAM_AW-1:0] src,
   input  logic [IMEM_AW-1:0] dst,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [WORD_W-1:0]  sram_rdata,
   output logic               sram_re,
   output logic [SRAM_AW-1:0] sram_raddr,
   output logic               imem_we,
   output logic [IMEM_AW-1:0] imem_addr,
   output logic [WORD_W-1:0]  imem_wdata,
   output logic               busy,
   output logic               done
);
   logic               busy_q, done_q, vld_q;
   logic [SRAM_AW-1:0] rd_ptr_q;
   logic [IMEM_AW-1:0] wr_ptr_q;
   logic [CNT_W-1:0]   left_q;
   logic               issue_ok;
   logic               finish;

   generate
      if (BACK2BACK) begin : g_stream
         // a read may issue while the previous word is being written
         assign issue_ok = 1'b1;
      end else begin : g_alternate
         // read and write phases alternate: two cycles per dword
         assign issue_ok = !vld_q;
      end
   endgenerate

   assign sram_re    = busy_q && (left_q != '0) && issue_ok;
   assign sram_raddr = rd_ptr_q;
   assign imem_we    = vld_q;
   assign imem_addr  = wr_ptr_q;
   assign imem_wdata = sram_rdata;
   assign finish     = busy_q && (left_q == '0) && !vld_q;
   assign busy       = busy_q;
   assign done       = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         vld_q    <= 1'b0;
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         left_q   <= '0;
      end else if (start) begin
         busy_q   <= 1'b1;
         done_q   <= 1'b0;
         vld_q    <= 1'b0;
         rd_ptr_q <= src;
         wr_ptr_q <= dst;
         left_q   <= cnt;
      end else begin
         vld_q <= sram_re;
         if (sram_re) begin
            rd_ptr_q <= rd_ptr_q + SRAM_AW'(1);
            left_q   <= left_q - CNT_W'(1);
         end
         if (vld_q) wr_ptr_q <= wr_ptr_q + IMEM_AW'(1);
         if (finish) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
   import boot_copy_pkg::*;
#(
   parameter int SRAM_WORDS = 256,
   parameter int IMEM_AW    = 14,
   parameter bit BACK2BACK  = 1'b1,
   localparam int SRAM_AW   = $clog2(SRAM_WORDS),
   localparam int CNT_W     = SRAM_AW + 1,
   localparam int ADDR_W    = SRAM_AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [WORD_W-1:0]  bus_wdata,
   output logic [WORD_W-1:0]  bus_rdata,
   input  logic               pwr_up_evt,
   output logic               imem_we,
   output logic [IMEM_AW-1:0] imem_addr,
   output logic [WORD_W-1:0]  imem_wdata
);
   generate
      if (SRAM_WORDS != (1 << SRAM_AW)) begin : g_bad_words
         $error("SRAM_WORDS must be a power of two");
      end
      if (SRAM_AW < 3) begin : g_bad_small
         $error("SRAM_WORDS must be at least 8");
      end
      if (IMEM_AW < 1 || IMEM_AW > 30) begin : g_bad_imem
         $error("IMEM_AW out of range");
      end
   endgenerate

   logic               seq_busy, seq_done;
   logic               start_pulse, sw_start_req, arm_q;
   logic               sram_we, sram_re;
   logic [SRAM_AW-1:0] src_q, sram_raddr;
   logic [IMEM_AW-1:0] dst_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [WORD_W-1:0]  sw_rdata, eng_rdata;

   bcopy_regs #(
      .SRAM_AW(SRAM_AW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pwr_up_evt(pwr_up_evt),
      .busy(seq_busy), .done(seq_done), .sram_rdata(sw_rdata),
      .sram_we(sram_we), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
      .arm_q(arm_q), .sw_start_req(sw_start_req), .start_pulse(start_pulse)
   );

   bcopy_sram #(
      .WORDS(SRAM_WORDS), .AW(SRAM_AW), .DW(WORD_W)
   ) i_sram (
      .clk(clk),
      .sw_we(sram_we), .sw_addr(bus_addr[SRAM_AW-1:0]), .sw_wdata(bus_wdata),
      .sw_rdata(sw_rdata),
      .eng_re(sram_re), .eng_addr(sram_raddr), .eng_rdata(eng_rdata)
   );

   bcopy_seq #(
      .SRAM_AW(SRAM_AW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W), .BACK2BACK(BACK2BACK)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start_pulse),
      .src(src_q), .dst(dst_q), .cnt(cnt_q), .sram_rdata(eng_rdata),
      .sram_re(sram_re), .sram_raddr(sram_raddr),
      .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
      .busy(seq_busy), .done(seq_done)
   );
endmodule

// File: rtl/boot_copy_engine_chk.sv
module boot_copy_engine_chk #(
   parameter int IMEM_AW = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               imem_we,
   input logic [IMEM_AW-1:0] imem_addr,
   input logic               pwr_up_evt,
   input logic               busy,
   input logic               done,
   input logic               start_pulse,
   input logic               sw_start_req,
   input logic               arm
);
   logic               have_prev;
   logic [IMEM_AW-1:0] prev_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_addr <= '0;
      end else if (start_pulse) begin
         have_prev <= 1'b0;
      end else if (imem_we) begin
         have_prev <= 1'b1;
         prev_addr <= imem_addr;
      end
   end

   assert_write_in_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      imem_we |-> busy);

   assert_addr_ascends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (imem_we && have_prev) |-> (imem_addr == IMEM_AW'(prev_addr + 1'b1)));

   assert_end_sets_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_start_clears_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> (busy && !done));

   assert_done_idle_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_disarmed_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_up_evt && !arm && !sw_start_req && !busy) |=> !busy);
endmodule

bind boot_copy_engine boot_copy_engine_chk #(.IMEM_AW(IMEM_AW)) i_chk (
   .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
   .pwr_up_evt(pwr_up_evt), .busy(seq_busy), .done(seq_done),
   .start_pulse(start_pulse), .sw_start_req(sw_start_req), .arm(arm_q)
);

// File: tb/test_boot_copy_engine.sv
`timescale 1ns/1ps
module test_boot_copy_engine;
   localparam int IMEM_AW = 14;
   localparam logic [8:0] A_CTRL = 9'd0, A_SRC = 9'd1, A_DST = 9'd2,
                          A_CNT = 9'd3, A_STAT = 9'd4;
   localparam int LOG_N = 4096;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               bus_we = 1'b0;
   logic [8:0]         bus_addr = '0;
   logic [31:0]        bus_wdata = '0;
   logic [31:0]        bus_rdata;
   logic               pwr_up_evt = 1'b0;
   logic               imem_we;
   logic [IMEM_AW-1:0] imem_addr;
   logic [31:0]        imem_wdata;

   int vectors = 0;
   int miscompares = 0;
   int wr_n = 0;
   logic [IMEM_AW-1:0] log_a [LOG_N];
   logic [31:0]        log_d [LOG_N];
   logic [31:0]        shadow [256];
   bit                 arm_b = 1'b0;

   always #10 clk = ~clk;

   boot_copy_engine i_boot_copy_engine (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_up_evt(pwr_up_evt),
      .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata)
   );

   always @(negedge clk) begin
      if (rst_n && imem_we) begin
         if (wr_n < LOG_N) begin
            log_a[wr_n] = imem_addr;
            log_d[wr_n] = imem_wdata;
         end
         wr_n = wr_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int k = 0; k < 5000; k++) begin
         rd(A_CTRL, v);
         if (!v[31]) break;
         @(negedge clk);
      end
   endtask

   function automatic logic [31:0] exp_data(input int src, input int i);
      return shadow[(src + i) % 256];
   endfunction

   function automatic logic [IMEM_AW-1:0] exp_addr(input int dst, input int i);
      return IMEM_AW'((dst + i) % (1 << IMEM_AW));
   endfunction

   task automatic verify_log(input int base, input int src, input int dst,
                             input int cnt, input string req);
      int bad = 0;
      check(wr_n - base == cnt, req, wr_n - base, cnt);
      for (int i = 0; i < cnt && base + i < LOG_N; i++) begin
         if (log_a[base+i] !== exp_addr(dst, i) || log_d[base+i] !== exp_data(src, i)) begin
            if (bad == 0)
               $display("FAIL %s: write %0d actual %0h@%0h expected %0h@%0h", req, i,
                        log_d[base+i], log_a[base+i], exp_data(src, i), exp_addr(dst, i));
            bad++;
         end
      end
      vectors++;
      if (bad != 0) miscompares++;
   endtask

   task automatic copy(input int src, input int dst, input int cnt, input bit use_evt,
                       input string req);
      logic [31:0] v;
      int base = wr_n;
      wr(A_SRC, 32'(src));
      wr(A_DST, 32'(dst));
      wr(A_CNT, 32'(cnt));
      if (use_evt) begin
         @(negedge clk); pwr_up_evt = 1'b1;
         @(negedge clk); pwr_up_evt = 1'b0;
      end else begin
         wr(A_CTRL, {1'b1, arm_b, 30'b0});
      end
      rd(A_CTRL, v);
      check(v[31] == 1'b1, {req, " R3 busy"}, v, 32'h8000_0000);
      rd(A_STAT, v);
      check(v[0] == 1'b0, {req, " R4 done cleared"}, v, 0);
      wait_idle();
      rd(A_STAT, v);
      check(v == 32'd1, {req, " R4 done set"}, v, 1);
      verify_log(base, src, dst, cnt, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int base;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v);  check(v == 0, "R1 ctrl", v, 0);
      rd(A_STAT, v);  check(v == 0, "R1 status", v, 0);
      check(imem_we == 1'b0 && wr_n == 0, "R1 no write", 32'(wr_n), 0);

      // R10 fill retention memory
      for (int i = 0; i < 256; i++) begin
         shadow[i] = $urandom;
         wr({1'b1, 8'(i)}, shadow[i]);
      end
      for (int i = 0; i < 256; i += 37) begin
         rd({1'b1, 8'(i)}, v);
         check(v == shadow[i], "R10 readback", v, shadow[i]);
      end

      // R11 register readback
      wr(A_SRC, 32'hFFFF_FF5A); rd(A_SRC, v); check(v == 32'h5A, "R11 src", v, 32'h5A);
      wr(A_DST, 32'h0001_2345); rd(A_DST, v); check(v == 32'h2345, "R11 dst", v, 32'h2345);
      wr(A_CNT, 32'h0000_0123); rd(A_CNT, v); check(v == 32'h123, "R11 cnt", v, 32'h123);

      copy(0, 0, 5, 1'b0, "R2 short");
      copy(17, 16380, 9, 1'b0, "R2 dst wrap");
      copy(0, 200, 0, 1'b0, "R5 zero count");
      copy(250, 1000, 12, 1'b0, "R6 src wrap");
      copy(0, 4096, 256, 1'b0, "R6 full");

      // R7 second start and register rewrite during a copy
      base = wr_n;
      wr(A_SRC, 32'd5); wr(A_DST, 32'd100); wr(A_CNT, 32'd40);
      wr(A_CTRL, 32'h8000_0000);
      wr(A_SRC, 32'd77);
      wr(A_CTRL, 32'h8000_0000);
      wait_idle();
      verify_log(base, 5, 100, 40, "R7 restart ignored");
      rd(A_SRC, v); check(v == 32'd77, "R11 src after R7", v, 77);

      // R8 arm and power-up replay
      arm_b = 1'b1;
      wr(A_CTRL, 32'h4000_0000);
      rd(A_CTRL, v); check(v == 32'h4000_0000, "R8 arm readback", v, 32'h4000_0000);
      copy(30, 60, 20, 1'b1, "R8 event copy");
      base = wr_n;
      @(negedge clk); pwr_up_evt = 1'b1;
      @(negedge clk); pwr_up_evt = 1'b0;
      wait_idle();
      verify_log(base, 30, 60, 20, "R8 replay");

      // R9 disarmed event
      arm_b = 1'b0;
      wr(A_CTRL, 32'h0);
      base = wr_n;
      @(negedge clk); pwr_up_evt = 1'b1;
      @(negedge clk); pwr_up_evt = 1'b0;
      repeat (6) @(negedge clk);
      check(wr_n == base, "R9 no writes", 32'(wr_n - base), 0);
      rd(A_CTRL, v); check(v == 0, "R9 ctrl", v, 0);
      rd(A_STAT, v); check(v == 1, "R9 done kept", v, 1);

      // random copies with occasional memory rewrites
      for (int n = 0; n < 25; n++) begin
         if (n % 4 == 0) begin
            for (int j = 0; j < 8; j++) begin
               int w = $urandom % 256;
               shadow[w] = $urandom;
               wr({1'b1, 8'(w)}, shadow[w]);
            end
         end
         copy($urandom % 256, $urandom % 16384, $urandom % 301, 1'b0, "R2 random");
      end

      // R10 copies leave the memory unchanged
      for (int i = 3; i < 256; i += 41) begin
         rd({1'b1, 8'(i)}, v);
         check(v == shadow[i], "R10 retained", v, shadow[i]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule